// File: doc/BRIEF.md
# Periodic Interval Timer with Elapsed-Period Counter

This block produces a steady time base from the master clock. A fixed power-of-two prescaler (sixteen by default) turns the clock into ticks. Each tick advances a current-value counter. When that counter reaches a programmed limit, it returns to zero. Each such wrap adds one to a saturating elapsed-period counter and sets a status flag. A level interrupt is raised when the status flag is set and the interrupt enable is on.

Software reaches the block through a small synchronous register bus. It programs the period, the timer enable and the interrupt enable in a control word. It reads the count in one of two ways. The acknowledging view returns the count and consumes the pending periods. The image view returns the same fields and changes nothing.

When the timer enable is cleared, counting continues until the current value comes back to zero, so the time base always stops at a clean period boundary.

Top module: `interval_tick_timer`

## Requirements
- R1: After reset every register reads zero, the interrupt is low and the current value does not advance.
- R2: While running, the current value advances exactly once every 16 clock cycles. The prescaler restarts from zero whenever counting stops.
- R3: Word address 0 is the control word: bits 19:0 hold the limit (period minus one), bit 24 the timer enable and bit 25 the interrupt enable. A write to it takes effect on the next cycle, and it reads back as written with the other bits zero.
- R4: The current value counts from 0 up to the limit and returns to 0 on the following tick. If the value is already above a newly written limit, it returns to 0 on the next tick.
- R5: Read data appears on `rd_data` in the cycle after `rd_en` and reflects the state at the time of the request. It is zero in cycles with no read and for addresses above 3. Word addresses 2 and 3 return the elapsed-period count in bits 31:20 and the current value in bits 19:0.
- R6: A read of word address 2 (acknowledge) clears the elapsed-period count and the status flag.
- R7: A read of word address 3 (image), or of addresses 0 and 1, leaves the count, the elapsed-period count and the status unchanged.
- R8: Word address 1 returns the status flag in bit 0. The flag is set by every wrap of the current value.
- R9: `irq` is high exactly when the status flag and the interrupt enable are both set. The interrupt enable has no effect on counting.
- R10: After the timer enable is cleared, counting continues until the current value returns to 0, then stops.
- R11: The elapsed-period count saturates at 4095.
- R12: If an acknowledge and a wrap fall in the same cycle, the elapsed-period count becomes 1 and the status flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 4 | Word address of the register access |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data, valid the cycle after `rd_en` |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that reset is held for at least one clock edge before any access. They also assume that `rd_en` is low while reset is asserted, so the first cycle after reset starts from a clean history. The bench meets both conditions: it drives all strobes low through reset, and it changes inputs only on the falling edge.

The bench deliberately aims an acknowledge at the exact cycle of a wrap. It also shrinks the limit below a running value, so the two merge and boundary rules are exercised rather than assumed.

// File: rtl/itt_pkg.sv
package itt_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_STAT  = 2'd1,
      SEL_ACK   = 2'd2,
      SEL_IMAGE = 2'd3
   } itt_sel_e;

   localparam int unsigned RUN_BIT  = 24;
   localparam int unsigned IRQE_BIT = 25;
endpackage

// File: rtl/itt_prescale.sv
module itt_prescale #(
   parameter int unsigned DIV = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic tick
);
   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV == 1) begin : g_bypass
         assign tick = run;
      end else begin : g_count
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] phase;

         always_ff @(posedge clk) begin
            if (rst)       phase <= '0;
            else if (!run) phase <= '0;
            else           phase <= phase + 1'b1;
         end

         assign tick = run && (phase == LAST);

         AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
            tick |=> !tick);                                   // R2
         AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (rst)
            !run |=> (phase == '0));                           // R2
      end
   endgenerate
endmodule

// File: rtl/itt_count.sv
module itt_count #(
   parameter int unsigned PER_W = 20,
   parameter int unsigned OVF_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             ack,
   input  logic [PER_W-1:0] limit,
   output logic [PER_W-1:0] cur,
   output logic [OVF_W-1:0] missed,
   output logic             pending,
   output logic             wrap
);
   localparam logic [OVF_W-1:0] MISSED_MAX = '1;
   localparam logic [OVF_W-1:0] MISSED_ONE = OVF_W'(1);

   assign wrap = tick && (cur >= limit);

   always_ff @(posedge clk) begin
      if (rst)       cur <= '0;
      else if (wrap) cur <= '0;
      else if (tick) cur <= cur + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         missed  <= '0;
         pending <= 1'b0;
      end else if (ack) begin
         missed  <= wrap ? MISSED_ONE : '0;
         pending <= wrap;
      end else if (wrap) begin
         missed  <= (missed == MISSED_MAX) ? missed : missed + 1'b1;
         pending <= 1'b1;
      end
   end

   AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
      !$past(tick) |-> (cur == $past(cur)));                   // R4
   AST_MISSED_SAT: assert property (@(posedge clk) disable iff (rst)
      ($past(missed) == MISSED_MAX && !$past(ack)) |-> (missed == MISSED_MAX)); // R11
   AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
      ($past(ack) && !$past(wrap)) |-> (missed == '0 && !pending));  // R6
   AST_ACK_MERGE: assert property (@(posedge clk) disable iff (rst)
      ($past(ack) && $past(wrap)) |-> (missed == MISSED_ONE && pending)); // R12
   AST_QUIET_READ: assert property (@(posedge clk) disable iff (rst)
      (!$past(ack) && !$past(wrap)) |->
         (missed == $past(missed) && pending == $past(pending)));     // R7
   AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
      $past(wrap) |-> pending);                                // R8
endmodule

// File: rtl/itt_regs.sv
module itt_regs
   import itt_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned PER_W  = 20,
   parameter int unsigned OVF_W  = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [PER_W-1:0]  cur,
   input  logic [OVF_W-1:0]  missed,
   input  logic              pending,
   output logic [PER_W-1:0]  limit,
   output logic              run_en,
   output logic              irq_en,
   output logic              ack,
   output logic [DATA_W-1:0] rd_data
);
   logic     in_map;
   itt_sel_e sel;
   logic     wdata_unused;

   assign in_map       = ((addr >> 2) == '0);
   assign sel          = itt_sel_e'(addr[1:0]);
   assign ack          = rd_en && in_map && (sel == SEL_ACK);
   assign wdata_unused = ^wr_data;

   always_ff @(posedge clk) begin
      if (rst) begin
         limit  <= '0;
         run_en <= 1'b0;
         irq_en <= 1'b0;
      end else if (wr_en && in_map && sel == SEL_CTRL) begin
         limit  <= wr_data[PER_W-1:0];
         run_en <= wr_data[RUN_BIT];
         irq_en <= wr_data[IRQE_BIT];
      end
   end

   logic [DATA_W-1:0] count_word, ctrl_word, stat_word, mux_word;

   always_comb begin
      count_word = '0;
      count_word[PER_W-1:0] = cur;
      count_word[DATA_W-1 -: OVF_W] = missed;
      ctrl_word = '0;
      ctrl_word[PER_W-1:0] = limit;
      ctrl_word[RUN_BIT]   = run_en;
      ctrl_word[IRQE_BIT]  = irq_en;
      stat_word = '0;
      stat_word[0] = pending;
      unique case (sel)
         SEL_CTRL:  mux_word = ctrl_word;
         SEL_STAT:  mux_word = stat_word;
         SEL_ACK,
         SEL_IMAGE: mux_word = count_word;
         default:   mux_word = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)                   rd_data <= '0;
      else if (rd_en && in_map)  rd_data <= mux_word;
      else                       rd_data <= '0;
   end

   AST_IDLE_BUS: assert property (@(posedge clk) disable iff (rst)
      !$past(rd_en) |-> (rd_data == '0));                      // R5
endmodule

// File: rtl/interval_tick_timer.sv
module interval_tick_timer #(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned PER_W    = 20,
   parameter int unsigned OVF_W    = 12,
   parameter int unsigned PRESCALE = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq
);
   generate
      if (PRESCALE == 0 || (PRESCALE & (PRESCALE - 1)) != 0) begin : g_bad_div
         $error("PRESCALE must be a power of two");
      end
      if (PER_W + OVF_W > DATA_W) begin : g_bad_pack
         $error("count fields do not fit the data word");
      end
      if (PER_W > itt_pkg::RUN_BIT || DATA_W <= itt_pkg::IRQE_BIT) begin : g_bad_ctrl
         $error("control bits overlap the limit field or exceed the word");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must cover four registers");
      end
   endgenerate

   logic [PER_W-1:0] limit, cur;
   logic [OVF_W-1:0] missed;
   logic             pending, run_en, irq_en, ack, tick, wrap, running;

   assign running = run_en || (cur != '0);
   assign irq     = pending && irq_en;

   itt_prescale #(.DIV(PRESCALE)) u_pre (
      .clk(clk), .rst(rst), .run(running), .tick(tick)
   );

   itt_count #(.PER_W(PER_W), .OVF_W(OVF_W)) u_cnt (
      .clk(clk), .rst(rst), .tick(tick), .ack(ack), .limit(limit),
      .cur(cur), .missed(missed), .pending(pending), .wrap(wrap)
   );

   itt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PER_W(PER_W), .OVF_W(OVF_W)) u_regs (
      .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .cur(cur), .missed(missed), .pending(pending),
      .limit(limit), .run_en(run_en), .irq_en(irq_en), .ack(ack),
      .rd_data(rd_data)
   );

   AST_HALT_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
      (!run_en && cur == '0) |=> (cur == '0));                 // R10
   AST_WRAP_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
      wrap |-> running);                                       // R2
endmodule

// File: tb/interval_tick_timer_tb_top.sv
module interval_tick_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   bit live = 0;

   always #10 clk = ~clk;

   interval_tick_timer dut_i (
      .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
   );

   // behavioural reference model
   int          m_pre = 0, m_cv = 0, m_ovf = 0, m_per = 0;
   bit          m_st = 0, m_en = 0, m_ie = 0;
   logic [31:0] m_rd = '0;

   function automatic logic [31:0] count_word(int ovf, int cv);
      return (32'(ovf) << 20) | 32'(cv);
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_pre = 0; m_cv = 0; m_ovf = 0; m_per = 0;
         m_st = 0; m_en = 0; m_ie = 0; m_rd = '0;
      end else begin
         bit go, tk, wr, ak;
         go = m_en || (m_cv != 0);
         tk = go && (m_pre == 15);
         wr = tk && (m_cv >= m_per);
         ak = rd_en && (addr == 4'd2);
         if (!rd_en)            m_rd = '0;
         else if (addr == 4'd0) m_rd = (32'(m_ie) << 25) | (32'(m_en) << 24) | 32'(m_per);
         else if (addr == 4'd1) m_rd = 32'(m_st);
         else if (addr == 4'd2 || addr == 4'd3) m_rd = count_word(m_ovf, m_cv);
         else                   m_rd = '0;
         m_pre = go ? (m_pre + 1) % 16 : 0;
         if (wr)      m_cv = 0;
         else if (tk) m_cv = (m_cv + 1) % (1 << 20);
         if (ak) begin
            m_ovf = wr ? 1 : 0;
            m_st  = wr;
         end else if (wr) begin
            if (m_ovf < 4095) m_ovf = m_ovf + 1;
            m_st = 1;
         end
         if (wr_en && addr == 4'd0) begin
            m_per = int'(wr_data[19:0]);
            m_en  = wr_data[24];
            m_ie  = wr_data[25];
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (live && !rst) begin
         check("R5 rd_data", rd_data, m_rd);
         check("R9 irq", 32'(irq), 32'(m_st && m_ie));
      end
   end

   task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   logic [31:0] d, d2;
   int last, t_prev, gap, maxcv, cvv;
   bit saw_wrap;

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      live = 1;

      // R1: reset state and stopped timer
      rd_reg(4'd0, d); check("R1 ctrl after reset", d, 32'h0);
      rd_reg(4'd1, d); check("R1 status after reset", d, 32'h0);
      idle(40);
      rd_reg(4'd3, d); check("R1 image stays zero", d, 32'h0);
      check("R1 irq low", 32'(irq), 32'h0);

      // R3: control word layout, limit 4 with timer enabled
      wr_reg(4'd0, 32'h0100_0004);
      rd_reg(4'd0, d); check("R3 ctrl readback", d, 32'h0100_0004);

      // R2 / R4: poll image continuously
      last = -1; t_prev = -1; gap = -1; maxcv = 0; saw_wrap = 0;
      @(negedge clk); addr = 4'd3; rd_en = 1'b1;
      for (int c = 0; c < 200; c++) begin
         @(negedge clk);
         cvv = int'(rd_data[19:0]);
         if (last >= 0 && cvv != last) begin
            if (t_prev >= 0) gap = c - t_prev;
            t_prev = c;
            if (cvv == 0 && last == 4) saw_wrap = 1;
         end
         if (cvv > maxcv) maxcv = cvv;
         last = cvv;
      end
      rd_en = 1'b0;
      check("R2 tick spacing", 32'(gap), 32'd16);
      check("R4 maximum value equals limit", 32'(maxcv), 32'd4);
      check("R4 wrap from limit to zero", 32'(saw_wrap), 32'd1);

      // R8 / R7 / R9
      rd_reg(4'd1, d); check("R8 status set after wrap", d, 32'h1);
      rd_reg(4'd3, d); check("R7 image elapsed nonzero", 32'(d[31:20] != 0), 32'h1);
      rd_reg(4'd1, d); check("R7 status kept after image", d, 32'h1);
      check("R9 irq off while disabled", 32'(irq), 32'h0);
      wr_reg(4'd0, 32'h0300_0004);
      check("R9 irq on when enabled", 32'(irq), 32'h1);

      // R6: acknowledge
      rd_reg(4'd2, d); check("R6 ack returns elapsed", 32'(d[31:20] != 0), 32'h1);
      rd_reg(4'd1, d); check("R6 status cleared", d, 32'(m_st));
      rd_reg(4'd3, d); check("R6 elapsed cleared", 32'(d[31:20]), 32'(m_ovf));

      // R12: acknowledge in the wrap cycle
      forever begin
         @(negedge clk);
         if ((m_en || m_cv != 0) && m_pre == 15 && m_cv >= m_per) break;
      end
      addr = 4'd2; rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
      rd_reg(4'd1, d); check("R12 status stays set", d, 32'h1);
      rd_reg(4'd3, d); check("R12 elapsed is one", 32'(d[31:20]), 32'd1);

      // R4: limit shrunk below running value
      wr_reg(4'd0, 32'h0100_0064);
      idle(16 * 40);
      wr_reg(4'd0, 32'h0100_000A);
      idle(20);
      rd_reg(4'd3, d); check("R4 shrink wraps to zero", 32'(d[19:0]), 32'(m_cv));
      check("R4 value restarted below limit", 32'(d[19:0] <= 20'd10), 32'h1);

      // R10: disable mid period
      idle(40);
      wr_reg(4'd0, 32'h0000_000A);
      idle(30);
      rd_reg(4'd3, d); check("R10 still counting after disable", 32'(d[19:0] != 0), 32'h1);
      idle(16 * 14);
      rd_reg(4'd3, d);
      check("R10 stopped at zero", 32'(d[19:0]), 32'h0);
      idle(100);
      rd_reg(4'd3, d2); check("R10 stays stopped", d2, d);

      // R11: saturation with limit zero
      rd_reg(4'd2, d);
      wr_reg(4'd0, 32'h0100_0000);
      idle(16 * 4110);
      rd_reg(4'd3, d); check("R11 saturated", 32'(d[31:20]), 32'd4095);
      idle(48);
      rd_reg(4'd2, d); check("R11 held at max", 32'(d[31:20]), 32'd4095);
      rd_reg(4'd3, d); check("R6 ack after saturation", 32'(d[31:20]), 32'(m_ovf));

      // R5: out-of-map read
      rd_reg(4'd9, d); check("R5 unmapped reads zero", d, 32'h0);

      idle(4);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule